// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the processor-facing register file of a byte-wide UART. A small address window of nineteen offsets is shared by several access modes. For every bus access the block works out which physical register the access reaches. The choice depends on the stored line control value and on two enable bits. The block keeps the configuration registers and drives their contents to the serial engine. The serial engine, the FIFOs and the baud generator live outside; their status bytes come in as inputs and are returned on reads.

Three overlays sit on top of the normal map. Setting bit 7 of the line control register opens the divisor bank. Loading the exact value 0xBF into line control opens the flow-character bank, and on its offsets that bank wins over the divisor bank. When bit 4 of the feature register and bit 6 of the modem control register are both set, and bit 7 of line control is clear, offsets 6 and 7 reach the FIFO trigger registers. The mode that applies to an access is always the one set up by the accesses that came before it.

Top module: `ubank_regfile`

## Requirements
- R1: After reset, line control, modem control, interrupt enable, feature control and the 16-bit divisor all read 0x00, and the operating mode register holds 0x07.
- R2: When line control bit 7 is 1, offset 0x00 reaches the divisor low byte, offset 0x01 reaches the divisor high byte, and offset 0x0F reaches a clock pre-scale select register instead of the auxiliary control register. `divisor` is {high, low}.
- R3: When line control equals 0xBF, offset 0x02 reaches feature control, and offsets 0x04, 0x05, 0x06 and 0x07 reach XON char 1, XON char 2, XOFF char 1 and XOFF char 2. On offsets 0x00, 0x01 and 0x0F the divisor bank still applies. `xon_chars` is {char 2, char 1} and `xoff_chars` is {char 2, char 1}.
- R4: Offsets 0x06 and 0x07 reach trigger control and trigger level only when feature bit 4 = 1, modem control bit 6 = 1 and line control bit 7 = 0. Otherwise offset 0x06 reads `modem_status` and offset 0x07 is the scratch byte.
- R5: With line control bit 7 = 0, a read of offset 0x00 returns `rx_data` and pulses `rx_pop` for one cycle. A write to offset 0x00 pulses `tx_push` for one cycle, with the written byte on `tx_data`.
- R6: With line control not 0xBF, offset 0x02 reads `irq_id`. A write there loads `fifo_ctl` and pulses `fifo_ctl_we` only when feature bit 4 = 1. Otherwise the write leaves `fifo_ctl` unchanged.
- R7: Offsets 0x0A to 0x0D read bytes 0 to 3 of `fifo_status`. Writes to them load bytes 0 to 3 of `fifo_thr`.
- R8: `uart_off` is 1 exactly when the operating mode register (offset 0x08, visible on `mode_sel`) holds 0x07.
- R9: Offsets 0x13 to 0x1F read 0x00, and writes to them change no register.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe. Status registers return the input value sampled with the strobe. In any cycle that follows no read, `bus_rdata` is 0x00.
- R11: The bank used for an access comes from the registered line control value. A line control write applies from the next access. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Head of the receive FIFO |
| irq_id | input | 8 | Interrupt identification byte |
| line_status | input | 8 | Line status byte |
| modem_status | input | 8 | Modem status byte |
| tx_status | input | 8 | Transmit status byte (offset 0x11) |
| fifo_status | input | 32 | Four FIFO status bytes (offsets 0x0A-0x0D) |
| rx_pop | output | 1 | One-cycle pop toward the receive FIFO |
| tx_data | output | 8 | Last byte pushed toward the transmit FIFO |
| tx_push | output | 1 | One-cycle push toward the transmit FIFO |
| divisor | output | 16 | Baud divisor |
| line_ctl | output | 8 | Line control register |
| modem_ctl | output | 8 | Modem control register |
| int_en | output | 8 | Interrupt enable register |
| feat_ctl | output | 8 | Feature control register |
| xon_chars | output | 16 | XON characters |
| xoff_chars | output | 16 | XOFF characters |
| trig_ctl | output | 8 | Trigger control register |
| trig_lvl | output | 8 | Trigger level register |
| fifo_ctl | output | 8 | FIFO control register |
| fifo_ctl_we | output | 1 | One-cycle strobe on an accepted FIFO control write |
| mode_sel | output | 8 | Operating mode register |
| uart_off | output | 1 | UART disabled indication |
| fifo_thr | output | 32 | Four FIFO threshold bytes |

## Verification
The bench moves between banks by rewriting line control. It reaches the same offsets in every bank. A decoder that got the 0xBF priority wrong would land a flow character in the modem control register. A decoder that ignored the remaining divisor offsets in that mode would return the receive byte and pop the FIFO. The bench writes FIFO control with the feature bit clear, and then with it set. It also checks that the trigger registers drop out once line control bit 7 is raised again. A write to line control followed at once by a read, and a read and write together in one cycle, show whether the bank choice and the read value use the registered state or the new value.

// File: rtl/ubank_pkg.sv
package ubank_pkg;

  localparam int DW       = 8;
  localparam int LVL_N    = 4;
  localparam int LVL_BASE = 10;
  localparam int LVL_IW   = $clog2(LVL_N);

  typedef enum logic [4:0] {
    T_NONE, T_RXTX, T_INTEN, T_IIRFCR, T_LINE, T_MODEM, T_LSTAT, T_MSTAT,
    T_SCRATCH, T_MODE, T_MODE2, T_LVL, T_BRK, T_AUX, T_SUP, T_TXSTAT,
    T_EBRK, T_DIVLO, T_DIVHI, T_CLKSEL, T_FEAT, T_XON1, T_XON2, T_XOFF1,
    T_XOFF2, T_TRIGC, T_TRIGL
  } tgt_e;

  typedef struct packed {
    logic [DW-1:0] line_ctl;
    logic [DW-1:0] modem_ctl;
    logic [DW-1:0] int_en;
    logic [DW-1:0] feat_ctl;
    logic [DW-1:0] div_lo;
    logic [DW-1:0] div_hi;
    logic [DW-1:0] clk_sel;
    logic [DW-1:0] xon1;
    logic [DW-1:0] xon2;
    logic [DW-1:0] xoff1;
    logic [DW-1:0] xoff2;
    logic [DW-1:0] trig_c;
    logic [DW-1:0] trig_l;
    logic [DW-1:0] fifo_ctl;
    logic [DW-1:0] mode_sel;
    logic [DW-1:0] mode2;
    logic [DW-1:0] brk;
    logic [DW-1:0] aux;
    logic [DW-1:0] sup;
    logic [DW-1:0] ebrk;
    logic [DW-1:0] scratch;
  } cfg_t;

endpackage

// File: rtl/ubank_rst_sync.sv
module ubank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ubank_decode.sv
module ubank_decode
  import ubank_pkg::*;
#(
  parameter int            ADDR_W      = 5,
  parameter logic [DW-1:0] FEAT_KEY    = 8'hBF,
  parameter int            DIV_BIT     = 7,
  parameter int            FEAT_EN_BIT = 4,
  parameter int            TRIG_EN_BIT = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     line_ctl_i,
  input  logic [DW-1:0]     feat_ctl_i,
  input  logic [DW-1:0]     modem_ctl_i,
  output tgt_e              tgt_o,
  output logic [LVL_IW-1:0] lvl_idx_o
);
  logic key_hit;
  logic div_on;
  logic trig_on;
  logic [ADDR_W-1:0] rel;

  assign key_hit = (line_ctl_i == FEAT_KEY);
  assign div_on  = line_ctl_i[DIV_BIT];
  assign trig_on = feat_ctl_i[FEAT_EN_BIT] & modem_ctl_i[TRIG_EN_BIT] & ~div_on;
  assign rel       = addr_i - ADDR_W'(LVL_BASE);
  assign lvl_idx_o = rel[LVL_IW-1:0];

  // Priority per offset: flow-character bank, then divisor bank,
  // then trigger bank, then the normal map.
  always_comb begin
    tgt_o = T_NONE;
    case (int'(addr_i))
      0:  tgt_o = div_on  ? T_DIVLO : T_RXTX;
      1:  tgt_o = div_on  ? T_DIVHI : T_INTEN;
      2:  tgt_o = key_hit ? T_FEAT  : T_IIRFCR;
      3:  tgt_o = T_LINE;
      4:  tgt_o = key_hit ? T_XON1  : T_MODEM;
      5:  tgt_o = key_hit ? T_XON2  : T_LSTAT;
      6:  tgt_o = key_hit ? T_XOFF1 : (trig_on ? T_TRIGC : T_MSTAT);
      7:  tgt_o = key_hit ? T_XOFF2 : (trig_on ? T_TRIGL : T_SCRATCH);
      8:  tgt_o = T_MODE;
      9:  tgt_o = T_MODE2;
      10, 11, 12, 13: tgt_o = T_LVL;
      14: tgt_o = T_BRK;
      15: tgt_o = div_on ? T_CLKSEL : T_AUX;
      16: tgt_o = T_SUP;
      17: tgt_o = T_TXSTAT;
      18: tgt_o = T_EBRK;
      default: tgt_o = T_NONE;
    endcase
  end
endmodule

// File: rtl/ubank_store.sv
module ubank_store
  import ubank_pkg::*;
#(
  parameter logic [DW-1:0] MODE_RST    = 8'h07,
  parameter int            FEAT_EN_BIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [DW-1:0]       wdata_i,
  input  tgt_e                tgt_i,
  input  logic [LVL_IW-1:0]   lvl_idx_i,
  output cfg_t                cfg_o,
  output logic [LVL_N*DW-1:0] thr_o,
  output logic [DW-1:0]       tx_data_o,
  output logic                tx_push_o,
  output logic                fifo_ctl_we_o
);
  cfg_t          cfg_q, cfg_d;
  logic          cfg_en;
  logic          push_d, fwe_d;
  logic          push_q, fwe_q;
  logic [DW-1:0] txd_q;

  assign cfg_en = wr_i;
  assign push_d = wr_i & (tgt_i == T_RXTX);
  assign fwe_d  = wr_i & (tgt_i == T_IIRFCR) & cfg_q.feat_ctl[FEAT_EN_BIT];

  always_comb begin
    cfg_d = cfg_q;
    case (tgt_i)
      T_LINE:    cfg_d.line_ctl  = wdata_i;
      T_MODEM:   cfg_d.modem_ctl = wdata_i;
      T_INTEN:   cfg_d.int_en    = wdata_i;
      T_FEAT:    cfg_d.feat_ctl  = wdata_i;
      T_DIVLO:   cfg_d.div_lo    = wdata_i;
      T_DIVHI:   cfg_d.div_hi    = wdata_i;
      T_CLKSEL:  cfg_d.clk_sel   = wdata_i;
      T_XON1:    cfg_d.xon1      = wdata_i;
      T_XON2:    cfg_d.xon2      = wdata_i;
      T_XOFF1:   cfg_d.xoff1     = wdata_i;
      T_XOFF2:   cfg_d.xoff2     = wdata_i;
      T_TRIGC:   cfg_d.trig_c    = wdata_i;
      T_TRIGL:   cfg_d.trig_l    = wdata_i;
      T_IIRFCR:  if (cfg_q.feat_ctl[FEAT_EN_BIT]) cfg_d.fifo_ctl = wdata_i;
      T_MODE:    cfg_d.mode_sel  = wdata_i;
      T_MODE2:   cfg_d.mode2     = wdata_i;
      T_BRK:     cfg_d.brk       = wdata_i;
      T_AUX:     cfg_d.aux       = wdata_i;
      T_SUP:     cfg_d.sup       = wdata_i;
      T_EBRK:    cfg_d.ebrk      = wdata_i;
      T_SCRATCH: cfg_d.scratch   = wdata_i;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q          <= '0;
      cfg_q.mode_sel <= MODE_RST;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q <= 1'b0;
      fwe_q  <= 1'b0;
    end else begin
      push_q <= push_d;
      fwe_q  <= fwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      txd_q <= '0;
    else if (push_d) txd_q <= wdata_i;
  end

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    logic          lane_en;
    logic [DW-1:0] lane_q;
    assign lane_en = wr_i & (tgt_i == T_LVL) & (lvl_idx_i == LVL_IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= wdata_i;
    end
    assign thr_o[g*DW +: DW] = lane_q;
  end

  assign cfg_o         = cfg_q;
  assign tx_data_o     = txd_q;
  assign tx_push_o     = push_q;
  assign fifo_ctl_we_o = fwe_q;
endmodule

// File: rtl/ubank_rdpath.sv
module ubank_rdpath
  import ubank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_i,
  input  tgt_e                tgt_i,
  input  logic [LVL_IW-1:0]   lvl_idx_i,
  input  cfg_t                cfg_i,
  input  logic [DW-1:0]       rx_data_i,
  input  logic [DW-1:0]       irq_id_i,
  input  logic [DW-1:0]       line_status_i,
  input  logic [DW-1:0]       modem_status_i,
  input  logic [DW-1:0]       tx_status_i,
  input  logic [LVL_N*DW-1:0] fifo_status_i,
  output logic [DW-1:0]       rdata_o,
  output logic                rx_pop_o
);
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_d, rdata_q;
  logic          pop_d, pop_q;

  always_comb begin
    rd_mux = '0;
    case (tgt_i)
      T_RXTX:    rd_mux = rx_data_i;
      T_INTEN:   rd_mux = cfg_i.int_en;
      T_IIRFCR:  rd_mux = irq_id_i;
      T_LINE:    rd_mux = cfg_i.line_ctl;
      T_MODEM:   rd_mux = cfg_i.modem_ctl;
      T_LSTAT:   rd_mux = line_status_i;
      T_MSTAT:   rd_mux = modem_status_i;
      T_SCRATCH: rd_mux = cfg_i.scratch;
      T_MODE:    rd_mux = cfg_i.mode_sel;
      T_MODE2:   rd_mux = cfg_i.mode2;
      T_LVL:     rd_mux = fifo_status_i[lvl_idx_i*DW +: DW];
      T_BRK:     rd_mux = cfg_i.brk;
      T_AUX:     rd_mux = cfg_i.aux;
      T_SUP:     rd_mux = cfg_i.sup;
      T_TXSTAT:  rd_mux = tx_status_i;
      T_EBRK:    rd_mux = cfg_i.ebrk;
      T_DIVLO:   rd_mux = cfg_i.div_lo;
      T_DIVHI:   rd_mux = cfg_i.div_hi;
      T_CLKSEL:  rd_mux = cfg_i.clk_sel;
      T_FEAT:    rd_mux = cfg_i.feat_ctl;
      T_XON1:    rd_mux = cfg_i.xon1;
      T_XON2:    rd_mux = cfg_i.xon2;
      T_XOFF1:   rd_mux = cfg_i.xoff1;
      T_XOFF2:   rd_mux = cfg_i.xoff2;
      T_TRIGC:   rd_mux = cfg_i.trig_c;
      T_TRIGL:   rd_mux = cfg_i.trig_l;
      default:   rd_mux = '0;
    endcase
  end

  assign rdata_d = rd_i ? rd_mux : '0;
  assign pop_d   = rd_i & (tgt_i == T_RXTX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      pop_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      pop_q   <= pop_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rx_pop_o = pop_q;
endmodule

// File: rtl/ubank_regfile.sv
module ubank_regfile
  import ubank_pkg::*;
#(
  parameter int            ADDR_W      = 5,
  parameter logic [DW-1:0] FEAT_KEY    = 8'hBF,
  parameter int            DIV_BIT     = 7,
  parameter int            FEAT_EN_BIT = 4,
  parameter int            TRIG_EN_BIT = 6,
  parameter logic [DW-1:0] MODE_RST    = 8'h07,
  parameter logic [DW-1:0] MODE_OFF    = 8'h07
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output logic [DW-1:0]       bus_rdata,
  input  logic [DW-1:0]       rx_data,
  input  logic [DW-1:0]       irq_id,
  input  logic [DW-1:0]       line_status,
  input  logic [DW-1:0]       modem_status,
  input  logic [DW-1:0]       tx_status,
  input  logic [LVL_N*DW-1:0] fifo_status,
  output logic                rx_pop,
  output logic [DW-1:0]       tx_data,
  output logic                tx_push,
  output logic [2*DW-1:0]     divisor,
  output logic [DW-1:0]       line_ctl,
  output logic [DW-1:0]       modem_ctl,
  output logic [DW-1:0]       int_en,
  output logic [DW-1:0]       feat_ctl,
  output logic [2*DW-1:0]     xon_chars,
  output logic [2*DW-1:0]     xoff_chars,
  output logic [DW-1:0]       trig_ctl,
  output logic [DW-1:0]       trig_lvl,
  output logic [DW-1:0]       fifo_ctl,
  output logic                fifo_ctl_we,
  output logic [DW-1:0]       mode_sel,
  output logic                uart_off,
  output logic [LVL_N*DW-1:0] fifo_thr
);
  logic              rst_n_s;
  tgt_e              tgt;
  logic [LVL_IW-1:0] lvl_idx;
  cfg_t              cfg;

  ubank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ubank_decode #(
    .ADDR_W      (ADDR_W),
    .FEAT_KEY    (FEAT_KEY),
    .DIV_BIT     (DIV_BIT),
    .FEAT_EN_BIT (FEAT_EN_BIT),
    .TRIG_EN_BIT (TRIG_EN_BIT)
  ) u_dec (
    .addr_i      (bus_addr),
    .line_ctl_i  (cfg.line_ctl),
    .feat_ctl_i  (cfg.feat_ctl),
    .modem_ctl_i (cfg.modem_ctl),
    .tgt_o       (tgt),
    .lvl_idx_o   (lvl_idx)
  );

  ubank_store #(
    .MODE_RST    (MODE_RST),
    .FEAT_EN_BIT (FEAT_EN_BIT)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .wr_i          (bus_wr),
    .wdata_i       (bus_wdata),
    .tgt_i         (tgt),
    .lvl_idx_i     (lvl_idx),
    .cfg_o         (cfg),
    .thr_o         (fifo_thr),
    .tx_data_o     (tx_data),
    .tx_push_o     (tx_push),
    .fifo_ctl_we_o (fifo_ctl_we)
  );

  ubank_rdpath u_rd (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .rd_i           (bus_rd),
    .tgt_i          (tgt),
    .lvl_idx_i      (lvl_idx),
    .cfg_i          (cfg),
    .rx_data_i      (rx_data),
    .irq_id_i       (irq_id),
    .line_status_i  (line_status),
    .modem_status_i (modem_status),
    .tx_status_i    (tx_status),
    .fifo_status_i  (fifo_status),
    .rdata_o        (bus_rdata),
    .rx_pop_o       (rx_pop)
  );

  assign divisor    = {cfg.div_hi, cfg.div_lo};
  assign line_ctl   = cfg.line_ctl;
  assign modem_ctl  = cfg.modem_ctl;
  assign int_en     = cfg.int_en;
  assign feat_ctl   = cfg.feat_ctl;
  assign xon_chars  = {cfg.xon2, cfg.xon1};
  assign xoff_chars = {cfg.xoff2, cfg.xoff1};
  assign trig_ctl   = cfg.trig_c;
  assign trig_lvl   = cfg.trig_l;
  assign fifo_ctl   = cfg.fifo_ctl;
  assign mode_sel   = cfg.mode_sel;
  assign uart_off   = (cfg.mode_sel == MODE_OFF);
endmodule

// File: rtl/ubank_chk.sv
module ubank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata,
  input logic        rx_pop,
  input logic [7:0]  tx_data,
  input logic        tx_push,
  input logic [15:0] divisor,
  input logic [7:0]  line_ctl,
  input logic [7:0]  modem_ctl,
  input logic [7:0]  feat_ctl,
  input logic [15:0] xon_chars,
  input logic [7:0]  trig_ctl,
  input logic [7:0]  fifo_ctl
);
  // R5
  rx_pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> ($past(bus_rd) && $past(bus_addr) == 5'd0 && !$past(line_ctl[7])));

  // R5
  tx_push_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> ($past(bus_wr) && $past(bus_addr) == 5'd0 && !$past(line_ctl[7])
                 && tx_data == $past(bus_wdata)));

  // R6
  fifo_ctl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fifo_ctl) |-> ($past(bus_wr) && $past(feat_ctl[4]) && $past(bus_addr) == 5'd2));

  // R2
  divisor_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divisor) |-> ($past(bus_wr) && $past(line_ctl[7])));

  // R3
  xon_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xon_chars) |-> ($past(bus_wr) && $past(line_ctl) == 8'hBF));

  // R4
  trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trig_ctl) |-> ($past(feat_ctl[4]) && $past(modem_ctl[6]) && !$past(line_ctl[7])));

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == 8'h00));
endmodule

bind ubank_regfile ubank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_rdata  (bus_rdata),
  .rx_pop     (rx_pop),
  .tx_data    (tx_data),
  .tx_push    (tx_push),
  .divisor    (divisor),
  .line_ctl   (line_ctl),
  .modem_ctl  (modem_ctl),
  .feat_ctl   (feat_ctl),
  .xon_chars  (xon_chars),
  .trig_ctl   (trig_ctl),
  .fifo_ctl   (fifo_ctl)
);

// File: tb/ubank_regfile_bench.sv
module ubank_regfile_bench;
  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_rdata;
  logic [7:0]  rx_data, irq_id, line_status, modem_status, tx_status;
  logic [31:0] fifo_status;
  logic        rx_pop, tx_push, fifo_ctl_we, uart_off;
  logic [7:0]  tx_data, line_ctl, modem_ctl, int_en, feat_ctl;
  logic [7:0]  trig_ctl, trig_lvl, fifo_ctl, mode_sel;
  logic [15:0] divisor, xon_chars, xoff_chars;
  logic [31:0] fifo_thr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ubank_regfile u_ubank_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .irq_id(irq_id), .line_status(line_status),
    .modem_status(modem_status), .tx_status(tx_status), .fifo_status(fifo_status),
    .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push), .divisor(divisor),
    .line_ctl(line_ctl), .modem_ctl(modem_ctl), .int_en(int_en), .feat_ctl(feat_ctl),
    .xon_chars(xon_chars), .xoff_chars(xoff_chars), .trig_ctl(trig_ctl),
    .trig_lvl(trig_lvl), .fifo_ctl(fifo_ctl), .fifo_ctl_we(fifo_ctl_we),
    .mode_sel(mode_sel), .uart_off(uart_off), .fifo_thr(fifo_thr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: a register file held as a table indexed by name.
  logic [7:0] m [string];
  logic [7:0] m_thr [4];
  logic [7:0] e_rdata, e_txd;
  logic       e_pop, e_push, e_fwe;
  logic       is_key, is_div, is_trig;

  function automatic logic [7:0] ref_read(input int a);
    case (a)
      0:  return is_div ? m["dlo"] : rx_data;
      1:  return is_div ? m["dhi"] : m["ien"];
      2:  return is_key ? m["feat"] : irq_id;
      3:  return m["lcr"];
      4:  return is_key ? m["x1"] : m["mcr"];
      5:  return is_key ? m["x2"] : line_status;
      6:  return is_key ? m["f1"] : (is_trig ? m["tc"] : modem_status);
      7:  return is_key ? m["f2"] : (is_trig ? m["tl"] : m["spr"]);
      8:  return m["mode"];
      9:  return m["mode2"];
      10, 11, 12, 13: return fifo_status[(a-10)*8 +: 8];
      14: return m["brk"];
      15: return is_div ? m["csel"] : m["aux"];
      16: return m["sup"];
      17: return tx_status;
      18: return m["ebrk"];
      default: return 8'h00;
    endcase
  endfunction

  task automatic ref_write(input int a, input logic [7:0] d);
    case (a)
      0:  if (is_div) m["dlo"] = d;
      1:  if (is_div) m["dhi"] = d; else m["ien"] = d;
      2:  if (is_key) m["feat"] = d; else if (m["feat"][4]) m["fcr"] = d;
      3:  m["lcr"] = d;
      4:  if (is_key) m["x1"] = d; else m["mcr"] = d;
      5:  if (is_key) m["x2"] = d;
      6:  if (is_key) m["f1"] = d; else if (is_trig) m["tc"] = d;
      7:  if (is_key) m["f2"] = d; else if (is_trig) m["tl"] = d; else m["spr"] = d;
      8:  m["mode"] = d;
      9:  m["mode2"] = d;
      10, 11, 12, 13: m_thr[a-10] = d;
      14: m["brk"] = d;
      15: if (is_div) m["csel"] = d; else m["aux"] = d;
      16: m["sup"] = d;
      18: m["ebrk"] = d;
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m[k]) m[k] = 8'h00;
      for (int i = 0; i < 4; i++) m_thr[i] = 8'h00;
      m["mode"] = 8'h07;
      e_rdata = 0; e_txd = 0; e_pop = 0; e_push = 0; e_fwe = 0;
    end else begin
      is_key  = (m["lcr"] == 8'hBF);
      is_div  = m["lcr"][7];
      is_trig = m["feat"][4] && m["mcr"][6] && !is_div;
      e_rdata = bus_rd ? ref_read(int'(bus_addr)) : 8'h00;
      e_pop   = bus_rd && bus_addr == 5'd0 && !is_div;
      e_push  = bus_wr && bus_addr == 5'd0 && !is_div;
      if (e_push) e_txd = bus_wdata;
      e_fwe   = bus_wr && bus_addr == 5'd2 && !is_key && m["feat"][4];
      if (bus_wr) ref_write(int'(bus_addr), bus_wdata);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 rdata", bus_rdata, e_rdata);
      check("R5 rx_pop", rx_pop, e_pop);
      check("R5 tx_push", tx_push, e_push);
      check("R5 tx_data", tx_data, e_txd);
      check("R6 fifo_ctl_we", fifo_ctl_we, e_fwe);
      check("R6 fifo_ctl", fifo_ctl, m["fcr"]);
      check("R2 divisor", divisor, {m["dhi"], m["dlo"]});
      check("R11 line_ctl", line_ctl, m["lcr"]);
      check("R1 modem_ctl", modem_ctl, m["mcr"]);
      check("R1 int_en", int_en, m["ien"]);
      check("R3 feat_ctl", feat_ctl, m["feat"]);
      check("R3 xon", xon_chars, {m["x2"], m["x1"]});
      check("R3 xoff", xoff_chars, {m["f2"], m["f1"]});
      check("R4 trig_ctl", trig_ctl, m["tc"]);
      check("R4 trig_lvl", trig_lvl, m["tl"]);
      check("R8 mode_sel", mode_sel, m["mode"]);
      check("R8 uart_off", uart_off, m["mode"] == 8'h07);
      check("R7 fifo_thr", fifo_thr, {m_thr[3], m_thr[2], m_thr[1], m_thr[0]});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rdx(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    foreach (m[k]) m[k] = 8'h00;
    m["lcr"] = 0;  m["mcr"] = 0;  m["ien"] = 0;  m["feat"] = 0; m["dlo"] = 0;
    m["dhi"] = 0;  m["csel"] = 0; m["x1"] = 0;   m["x2"] = 0;   m["f1"] = 0;
    m["f2"] = 0;   m["tc"] = 0;   m["tl"] = 0;   m["fcr"] = 0;  m["mode"] = 8'h07;
    m["mode2"] = 0; m["brk"] = 0; m["aux"] = 0;  m["sup"] = 0;  m["ebrk"] = 0;
    m["spr"] = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    rx_data = 8'h5A; irq_id = 8'hC1; line_status = 8'h61; modem_status = 8'hB0;
    tx_status = 8'h02; fifo_status = 32'h44332211;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state at the ports
    check("R1 line_ctl reset", line_ctl, 8'h00);
    check("R1 feat_ctl reset", feat_ctl, 8'h00);
    check("R1 divisor reset", divisor, 16'h0000);
    check("R1 mode_sel reset", mode_sel, 8'h07);
    check("R8 uart_off reset", uart_off, 1'b1);
    rdx(5'h08, 8'h07, "R1 mode read");

    // R5 normal receive/transmit offset
    rdx(5'h00, 8'h5A, "R5 rx read");
    wr(5'h00, 8'hA5); idle();
    check("R5 tx_data", tx_data, 8'hA5);

    // R2 divisor bank
    wr(5'h03, 8'h80);
    rdx(5'h00, 8'h00, "R2 divisor low reset");
    wr(5'h00, 8'h34); wr(5'h01, 8'h12); wr(5'h0F, 8'h03);
    rdx(5'h00, 8'h34, "R2 divisor low");
    rdx(5'h0F, 8'h03, "R2 clock select");
    check("R2 divisor port", divisor, 16'h1234);
    wr(5'h03, 8'h03);
    rdx(5'h0F, 8'h00, "R2 aux separate");
    rx_data = 8'h3C;
    rdx(5'h00, 8'h3C, "R5 rx after divisor");
    rdx(5'h01, 8'h00, "R1 int_en read");

    // R6 FIFO control gated by feature bit 4
    wr(5'h02, 8'hC7); idle();
    check("R6 fifo_ctl blocked", fifo_ctl, 8'h00);

    // R3 flow-character bank and its priority
    wr(5'h03, 8'hBF);
    wr(5'h02, 8'h10); wr(5'h04, 8'h11); wr(5'h05, 8'h22);
    wr(5'h06, 8'h33); wr(5'h07, 8'h44);
    rdx(5'h00, 8'h34, "R3 divisor under key");
    rdx(5'h02, 8'h10, "R3 feature read");
    rdx(5'h06, 8'h33, "R3 xoff1 read");
    check("R3 modem_ctl untouched", modem_ctl, 8'h00);
    check("R3 xon port", xon_chars, 16'h2211);

    wr(5'h03, 8'h03);
    wr(5'h02, 8'hC7); idle();
    check("R6 fifo_ctl loaded", fifo_ctl, 8'hC7);
    rdx(5'h02, 8'hC1, "R6 irq id read");

    // R4 trigger bank
    rdx(5'h06, 8'hB0, "R4 modem status");
    wr(5'h04, 8'h40);
    wr(5'h06, 8'h9A); wr(5'h07, 8'h5C);
    rdx(5'h06, 8'h9A, "R4 trig ctl");
    rdx(5'h07, 8'h5C, "R4 trig lvl");
    wr(5'h03, 8'h83);
    rdx(5'h06, 8'hB0, "R4 off under bit7");
    wr(5'h03, 8'h03);

    // R7 FIFO status and threshold bytes
    for (int i = 0; i < 4; i++) wr(5'(10 + i), 8'(8'hE0 + i));
    rdx(5'h0C, 8'h33, "R7 status byte 2");
    check("R7 thresholds", fifo_thr, 32'hE3E2E1E0);

    // R8 operating mode
    wr(5'h08, 8'h00); idle();
    check("R8 uart on", uart_off, 1'b0);
    wr(5'h08, 8'h07); idle();
    check("R8 uart off", uart_off, 1'b1);

    // R9 unmapped offsets
    wr(5'h13, 8'hFF);
    rdx(5'h13, 8'h00, "R9 read 0x13");
    rdx(5'h1F, 8'h00, "R9 read 0x1F");

    // R11 line control applies from the next access
    wr(5'h03, 8'h80);
    rdx(5'h00, 8'h34, "R11 next access");
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 5'h03; bus_wdata = 8'h03;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R11 read before write", bus_rdata, 8'h80);
    rdx(5'h03, 8'h03, "R11 new value");
    rdx(5'h00, 8'h3C, "R11 normal again");

    repeat (3) idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule